// File: doc/BRIEF.md
# Microstep Pulse Burst Generator

This block drives one channel of a stepper motor controller. In each frame it emits a burst of step pulses, spaced evenly in reference-clock cycles, and it keeps a 6-bit microstep position index that moves by one on every pulse. Sixty-four positions make one electrical cycle, sixteen per quadrant. Turning the index into coil current levels is done elsewhere.

A frame is framed by two single-cycle strobes from the frame timing logic. One marks the end of the initial wait. The other marks the end of the settle window. When the settle-window strobe arrives, the block samples the pulse count, pulse spacing and direction, and it starts a new burst. A burst that is still running at that moment is dropped. The drive-enable output follows a programmed enable bit, but that bit is only taken at the frame boundaries. The position index keeps moving while the drive is switched off, so the winding phase stays in step with the commanded motion.

Top module: `step_burst_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pulse_o`, `gate_o`, `has_pulses_o`, `drive_en_o` are 0 and `pos_o` is 0.
- R2: A burst holds exactly `count_i` × 4 pulses. The 8-bit count therefore covers 0 to 1020 pulses in steps of four.
- R3: `pulse_o` is high for one cycle per pulse. Counting the cycle after the strobe's clock edge as offset 0, pulses appear at offsets P, 2P, 3P and so on, where P is `period_i` (1 to 65535). A period of 0 behaves as 1.
- R4: With `dir_i` = 0 each pulse adds 1 to `pos_o`. With `dir_i` = 1 each pulse subtracts 1. The index wraps modulo 64, and the new value shows in the same cycle as the pulse.
- R5: No pulse is produced, and `has_pulses_o` is 0 for the frame, when the count is 0, when `csum_ok_i` is 0, or when `pwr_save_i` is 1 at the settle strobe.
- R6: `gate_o` rises at offset 0 when the burst has pulses. It stays high while pulses remain and falls in the cycle of the last pulse.
- R7: The latched enable goes from 0 to 1 only on `ff1_fall_i` with `enable_i` = 1. It goes from 1 to 0 only on `ff2_fall_i` with `enable_i` = 0. Any other strobe and enable combination leaves it unchanged.
- R8: `pos_o` moves on every pulse whether or not `drive_en_o` is high.
- R9: A settle strobe that arrives during a burst ends that burst with no further pulse and starts the new burst at once.
- R10: `drive_en_o` equals the latched enable ANDed with NOT `pwr_save_i`, registered one cycle.
- R11: Count, period and direction are taken only at `ff2_fall_i`. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ff1_fall_i | input | 1 | One-cycle strobe at the end of the initial wait |
| ff2_fall_i | input | 1 | One-cycle strobe at the end of the settle window (starts a burst) |
| count_i | input | 8 | Pulse count in units of four |
| period_i | input | 16 | Pulse spacing in reference clocks |
| dir_i | input | 1 | 0 = step index up, 1 = step index down |
| enable_i | input | 1 | Requested drive enable |
| csum_ok_i | input | 1 | Frame checksum valid |
| pwr_save_i | input | 1 | Power-save request |
| pulse_o | output | 1 | Step pulse |
| gate_o | output | 1 | High while pulses of the burst remain |
| has_pulses_o | output | 1 | The current frame carries pulses |
| pos_o | output | 6 | Microstep position index |
| drive_en_o | output | 1 | Drive stage enable |

## Verification
On every cycle the assertions check four things. The interval timer never runs past the latched period. A pulse only appears while the gate was high. The gate never stands without the frame flag. The position moves by exactly one in the latched direction on a pulse and holds otherwise. They also check that each enable transition comes from the matching strobe and enable value.

Some behaviours depend on the full frame, so only the bench scenarios show them. These are the exact pulse count and the spacing within a burst, the wrap at 63/0, that period 0 behaves as 1, that mid-burst input changes are ignored, abort on a new strobe, and the power-save suppression of both the pulses and the drive enable.

// File: rtl/step_burst_pkg.sv
package step_burst_pkg;
  typedef enum logic {STEP_UP = 1'b0, STEP_DOWN = 1'b1} step_dir_e;

  function automatic logic [15:0] clamp_period(input logic [15:0] p);
    return (p == 16'd0) ? 16'd1 : p;
  endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int CNT_W = 8,
  parameter int SCALE_SH = 2,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             ok_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PER_W-1:0] per_i,
  output logic             fire_o,
  output logic             pulse_o,
  output logic             gate_o,
  output logic             has_o
);
  localparam int RUN_W = CNT_W + SCALE_SH;

  logic [RUN_W-1:0] rem_q;
  logic [PER_W-1:0] tmr_q, per_q;
  logic             pulse_q, gate_q, has_q;
  logic             load_ok;

  assign load_ok = ok_i && (cnt_i != '0);
  assign fire_o  = !start_i && (rem_q != '0) && (tmr_q >= per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      tmr_q   <= PER_W'(1);
      per_q   <= PER_W'(1);
      pulse_q <= 1'b0;
      gate_q  <= 1'b0;
      has_q   <= 1'b0;
    end else if (start_i) begin
      per_q   <= (per_i == '0) ? PER_W'(1) : per_i;
      tmr_q   <= PER_W'(1);
      pulse_q <= 1'b0;
      rem_q   <= load_ok ? {cnt_i, {SCALE_SH{1'b0}}} : '0;
      gate_q  <= load_ok;
      has_q   <= load_ok;
    end else begin
      pulse_q <= 1'b0;
      if (rem_q != '0) begin
        if (fire_o) begin
          pulse_q <= 1'b1;
          tmr_q   <= PER_W'(1);
          rem_q   <= rem_q - 1'b1;
          gate_q  <= (rem_q != RUN_W'(1));
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q;
  assign gate_o  = gate_q;
  assign has_o   = has_q;

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst) tmr_q <= per_q); // R3
  AST_PULSE_IN_GATE: assert property (@(posedge clk) disable iff (rst) pulse_q |-> $past(gate_q)); // R6
  AST_GATE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst) gate_q |-> has_q); // R5
endmodule

// File: rtl/pos_track.sv
module pos_track #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             dir_i,
  input  logic             step_i,
  output logic [POS_W-1:0] pos_o
);
  import step_burst_pkg::*;

  step_dir_e        dir_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= STEP_UP;
      pos_q <= '0;
    end else begin
      if (load_i) dir_q <= step_dir_e'(dir_i);
      if (step_i) pos_q <= (dir_q == STEP_UP) ? pos_q + 1'b1 : pos_q - 1'b1;
    end
  end

  assign pos_o = pos_q;

  AST_POS_UP: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_q == STEP_UP) |=> pos_q == POS_W'($past(pos_q) + 1'b1)); // R4
  AST_POS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_q == STEP_DOWN) |=> pos_q == POS_W'($past(pos_q) - 1'b1)); // R4
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst) !step_i |=> $stable(pos_q)); // R8
endmodule

// File: rtl/enable_latch.sv
module enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic ff1_fall_i,
  input  logic ff2_fall_i,
  input  logic en_i,
  input  logic ps_i,
  output logic drv_o
);
  logic en_q, en_nx, drv_q;

  always_comb begin
    en_nx = en_q;
    if (ff1_fall_i && en_i)       en_nx = 1'b1;
    else if (ff2_fall_i && !en_i) en_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      en_q  <= en_nx;
      drv_q <= en_nx && !ps_i;
    end
  end

  assign drv_o = drv_q;

  AST_EN_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(ff1_fall_i && en_i)); // R7
  AST_EN_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> $past(ff2_fall_i && !en_i)); // R7
  AST_PS_DRV_OFF: assert property (@(posedge clk) disable iff (rst) ps_i |=> !drv_q); // R10
endmodule

// File: rtl/step_burst_gen.sv
module step_burst_gen #(
  parameter int CNT_W = 8,
  parameter int SCALE_SH = 2,
  parameter int PER_W = 16,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ff1_fall_i,
  input  logic             ff2_fall_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             dir_i,
  input  logic             enable_i,
  input  logic             csum_ok_i,
  input  logic             pwr_save_i,
  output logic             pulse_o,
  output logic             gate_o,
  output logic             has_pulses_o,
  output logic [POS_W-1:0] pos_o,
  output logic             drive_en_o
);
  logic fire;
  logic frame_ok;

  assign frame_ok = csum_ok_i && !pwr_save_i;

  burst_seq #(.CNT_W(CNT_W), .SCALE_SH(SCALE_SH), .PER_W(PER_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(ff2_fall_i), .ok_i(frame_ok),
    .cnt_i(count_i), .per_i(period_i), .fire_o(fire),
    .pulse_o(pulse_o), .gate_o(gate_o), .has_o(has_pulses_o)
  );

  pos_track #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .load_i(ff2_fall_i), .dir_i(dir_i),
    .step_i(fire), .pos_o(pos_o)
  );

  enable_latch u_en (
    .clk(clk), .rst(rst), .ff1_fall_i(ff1_fall_i), .ff2_fall_i(ff2_fall_i),
    .en_i(enable_i), .ps_i(pwr_save_i), .drv_o(drive_en_o)
  );

  AST_NO_FRAME_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !has_pulses_o |-> !pulse_o); // R5
endmodule

// File: tb/step_burst_gen_test.sv
module step_burst_gen_test;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ff1 = 0, ff2 = 0, dir = 0, en = 0, cs = 1, ps = 0;
  logic [7:0] cnt = 0;
  logic [15:0] per = 1;
  logic pulse, gate, has, drv;
  logic [5:0] pos;
  logic [5:0] mpos = 0;
  int checks = 0, fails = 0;

  always #(CLK_PER/2) clk = ~clk;

  step_burst_gen uut (
    .clk(clk), .rst(rst), .ff1_fall_i(ff1), .ff2_fall_i(ff2), .count_i(cnt),
    .period_i(per), .dir_i(dir), .enable_i(en), .csum_ok_i(cs), .pwr_save_i(ps),
    .pulse_o(pulse), .gate_o(gate), .has_pulses_o(has), .pos_o(pos), .drive_en_o(drv)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe2();
    @(negedge clk); ff2 = 1;
    @(negedge clk); ff2 = 0;
  endtask

  task automatic run_burst(input logic [7:0] c, input logic [15:0] p, input logic d,
                           input logic csv, input logic psv);
    int expn, peff, np, bad;
    expn = (csv && !psv) ? c * 4 : 0;
    peff = (p == 0) ? 1 : p;
    np = 0; bad = 0;
    cnt = c; per = p; dir = d; cs = csv; ps = psv;
    strobe2();
    chk(gate == (expn != 0), "R6 gate at start", gate, expn != 0);
    chk(has == (expn != 0), "R5 frame flag", has, expn != 0);
    dir = ~d; per = p + 16'd5; cnt = c + 8'd1;  // R11: ignored mid-burst
    for (int i = 1; i <= expn * peff + 3; i++) begin
      @(negedge clk);
      if (pulse) begin
        np++;
        if (i % peff != 0) bad++;
        mpos = d ? mpos - 6'd1 : mpos + 6'd1;
      end
      if (pos != mpos) bad++;
      if (expn != 0 && i == expn * peff)
        chk(pulse && !gate, "R6 gate falls on last pulse", gate, 0);
    end
    chk(np == expn, "R2 pulse count", np, expn);
    chk(bad == 0, "R3/R4/R11 spacing and position", bad, 0);
    chk(pos == mpos, "R4 final position", pos, mpos);
    cs = 1; ps = 0;
  endtask

  task automatic t_reset();
    chk(!pulse && !gate && !has && !drv && pos == 0, "R1 reset state", {pulse, gate, has, drv}, 0);
    chk(pos == 0, "R1 reset position", pos, 0);
  endtask

  task automatic t_abort();
    int np = 0;
    cnt = 2; per = 2; dir = 0;
    strobe2();
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (pulse) np++;
    end
    mpos = mpos + 6'd2;
    cnt = 1; per = 1; dir = 1;
    @(negedge clk); ff2 = 1;
    @(negedge clk); ff2 = 0;
    chk(!pulse && gate, "R9 restart without stale pulse", pulse, 0);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (pulse) np++;
    end
    mpos = mpos - 6'd4;
    chk(np == 6, "R9 pulses across abort", np, 6);
    chk(pos == mpos, "R9 position after abort", pos, mpos);
  endtask

  task automatic t_enable();
    en = 1; cnt = 0;
    strobe2();
    chk(drv == 0, "R7 settle strobe cannot raise enable", drv, 0);
    @(negedge clk); ff1 = 1;
    @(negedge clk); ff1 = 0;
    chk(drv == 1, "R7 first-wait strobe raises enable", drv, 1);
    en = 0;
    @(negedge clk); ff1 = 1;
    @(negedge clk); ff1 = 0;
    chk(drv == 1, "R7 first-wait strobe cannot drop enable", drv, 1);
    ps = 1;
    @(negedge clk);
    chk(drv == 0, "R10 power save masks drive", drv, 0);
    ps = 0;
    @(negedge clk);
    chk(drv == 1, "R10 drive returns after power save", drv, 1);
    strobe2();
    chk(drv == 0, "R7 settle strobe drops enable", drv, 0);
  endtask

  initial begin
    #(CLK_PER * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    run_burst(8'd1, 16'd3, 1'b0, 1'b1, 1'b0);   // R2 R3 R4 forward
    run_burst(8'd2, 16'd1, 1'b1, 1'b1, 1'b0);   // R4 reverse, wrap below 0
    run_burst(8'd20, 16'd2, 1'b0, 1'b1, 1'b0);  // R4 wrap past 63
    run_burst(8'd1, 16'd0, 1'b0, 1'b1, 1'b0);   // R3 period 0 as 1
    run_burst(8'd0, 16'd2, 1'b0, 1'b1, 1'b0);   // R5 zero count
    run_burst(8'd3, 16'd2, 1'b0, 1'b0, 1'b0);   // R5 bad checksum
    run_burst(8'd3, 16'd2, 1'b0, 1'b1, 1'b1);   // R5 power save
    t_abort();
    t_enable();
    chk(drv == 0, "R8 drive off before burst", drv, 0);
    run_burst(8'd2, 16'd2, 1'b1, 1'b1, 1'b0);   // R8 moves while disabled
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule